// File: doc/BRIEF.md
# Nibble Rotate Execution Unit

This unit carries out one decimal-digit rotate-left instruction. The instruction moves three 4-bit digits around a cycle. The low digit of a memory byte moves up into that byte's high digit. The byte's old high digit goes to the accumulator's low digit. The accumulator's old low digit goes to the byte's low digit. The byte sits at the address held in a 16-bit pointer register pair.

A sequencer hands the unit the two-byte opcode together with a one-cycle start pulse. At the same time it presents the pointer, the accumulator and the flag register. The unit then runs one read of the operand over a simple ready-handshaked memory port and forms the results. It writes the new byte back to the same address. Last, it shows the new accumulator and flag byte together with a single-cycle done pulse. The unit goes back to idle after the done cycle. It ignores any start that arrives while it is working, and any start that carries a different opcode.

Top module: `nibble_rot_unit`

## Requirements
- R1: The unit starts only when start_i is high in idle and opcode_i equals 16'hED6F, with the first opcode byte (8'hED) in bits 15:8 and the second (8'h6F) in bits 7:0. Any other opcode causes no memory access, no done pulse and no change on acc_o or flags_o.
- R2: The read goes to the pointer value captured at start. mem_rd_o and mem_addr_o hold steady until mem_ready_i is seen high. The write goes to the same address.
- R3: The byte written is {old byte low digit, old accumulator low digit}. The digit in bits 3:0 of the read data ends up in bits 7:4 of the write data.
- R4: acc_o after the operation is {old accumulator high digit, old byte high digit}. The high digit passes through unchanged.
- R5: Flag bit 7 (sign) equals bit 7 of the new accumulator. Flag bit 6 (zero) is set exactly when the new accumulator is 8'h00.
- R6: Flag bit 2 (parity) is 1 when the new accumulator has an even number of 1 bits, and 0 when the count is odd.
- R7: Flag bit 4 (half carry) and flag bit 1 (subtract) are cleared. Flag bit 0 (carry) and the unused bits 5 and 3 keep the values of flags_i captured at start.
- R8: Each execution makes exactly one accepted read and then exactly one accepted write. mem_rd_o and mem_wr_o are never high together.
- R9: done_o is high for exactly one cycle. That cycle directly follows the cycle in which the write was accepted. acc_o and flags_o carry the results from that cycle on, until the next execution.
- R10: A start pulse that arrives while an execution is in progress is ignored. The result comes from the operands captured at the accepted start, and no extra access takes place.
- R11: While rst_n is low, mem_rd_o, mem_wr_o and done_o are low and acc_o and flags_o are 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle request to execute the presented opcode |
| opcode_i | input | 16 | Two-byte opcode, first byte in bits 15:8 |
| ptr_i | input | 16 | Pointer pair giving the operand address |
| acc_i | input | 8 | Accumulator value before the operation |
| flags_i | input | 8 | Flag register before the operation |
| mem_addr_o | output | 16 | Memory address for read and write |
| mem_rd_o | output | 1 | Read strobe, held until ready |
| mem_wr_o | output | 1 | Write strobe, held until ready |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Read data, valid when ready is high during a read |
| mem_ready_i | input | 1 | Memory acknowledge for the current strobe |
| acc_o | output | 8 | Accumulator result |
| flags_o | output | 8 | Flag register result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench runs every memory byte against all sixteen accumulator low digits, while the high digits, flag inputs, pointers and memory wait states keep changing. This catches a digit routed to the wrong place, which would corrupt one of the three moves for some values. It also catches a lost accumulator high digit and a parity or zero flag that is wrong only on a few byte values. It checks that the carry bit and the unused bits 5 and 3 come through from the input, so a design that clears them or drives them as constants is caught. It checks that near-miss opcodes (one byte changed, or the bytes swapped) and start pulses sent mid-execution cause no memory traffic and do not change the result. A design that decodes only part of the opcode, or reloads its operands while busy, fails these checks. It counts accesses and watches the done pulse, which catches double reads, early writes, a write to a different address, and a done that is late or lasts more than one cycle.

// File: rtl/nrot_pkg.sv
package nrot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_CALC  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } nrot_state_e;

  localparam int unsigned  BYTE_W     = 8;
  localparam int unsigned  FLAG_W     = 8;
  localparam logic [7:0]   OPC_PREFIX = 8'hED;
  localparam logic [7:0]   OPC_RLD    = 8'h6F;

  // flag register bit positions
  localparam int unsigned  FLG_S  = 7;
  localparam int unsigned  FLG_Z  = 6;
  localparam int unsigned  FLG_H  = 4;
  localparam int unsigned  FLG_PV = 2;
  localparam int unsigned  FLG_N  = 1;
  localparam int unsigned  FLG_C  = 0;

  // bits that pass through unchanged: carry and the two spare bits
  localparam logic [FLAG_W-1:0] FLG_KEEP_MASK = 8'b0010_1001;

endpackage

// File: rtl/nrot_digit_alu.sv
module nrot_digit_alu
  import nrot_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_old,
  input  logic [DATA_W-1:0] mem_old,
  input  logic [FLAG_W-1:0] flg_old,
  output logic [DATA_W-1:0] acc_new,
  output logic [DATA_W-1:0] mem_new,
  output logic [FLAG_W-1:0] flg_new
);

  localparam int unsigned NIB_W = DATA_W / 2;

  logic [NIB_W-1:0] acc_hi, acc_lo, mem_hi, mem_lo;
  logic [FLAG_W-1:0] flg_calc;
  logic              res_sign, res_zero, res_even;

  assign acc_hi = acc_old[DATA_W-1:NIB_W];
  assign acc_lo = acc_old[NIB_W-1:0];
  assign mem_hi = mem_old[DATA_W-1:NIB_W];
  assign mem_lo = mem_old[NIB_W-1:0];

  // three-way digit rotation
  assign mem_new = {mem_lo, acc_lo};
  assign acc_new = {acc_hi, mem_hi};

  assign res_sign = acc_new[DATA_W-1];
  assign res_zero = (acc_new == '0);
  assign res_even = ~(^acc_new);

  // computed flag bits; H and N stay zero
  generate
    for (genvar b = 0; b < FLAG_W; b++) begin : g_flag
      if (b == FLG_S) begin : g_s
        assign flg_calc[b] = res_sign;
      end else if (b == FLG_Z) begin : g_z
        assign flg_calc[b] = res_zero;
      end else if (b == FLG_PV) begin : g_pv
        assign flg_calc[b] = res_even;
      end else begin : g_zero
        assign flg_calc[b] = 1'b0;
      end
    end
  endgenerate

  assign flg_new = (flg_old & FLG_KEEP_MASK) | (flg_calc & ~FLG_KEEP_MASK);

endmodule

// File: rtl/nrot_ctrl.sv
module nrot_ctrl
  import nrot_pkg::*;
#(
  parameter int unsigned OPC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             mem_ready_i,
  output logic             load_op,
  output logic             load_rd,
  output logic             load_res,
  output logic             rd_en,
  output logic             wr_en,
  output logic             done
);

  nrot_state_e state_q, state_d;
  logic        opc_hit;

  assign opc_hit = (opcode_i == {OPC_PREFIX, OPC_RLD});

  always_comb begin
    state_d  = state_q;
    load_op  = 1'b0;
    load_rd  = 1'b0;
    load_res = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && opc_hit) begin
          load_op = 1'b1;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (mem_ready_i) begin
          load_rd = 1'b1;
          state_d = ST_CALC;
        end
      end
      ST_CALC: begin
        load_res = 1'b1;
        state_d  = ST_WRITE;
      end
      ST_WRITE: begin
        if (mem_ready_i) state_d = ST_DONE;
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign rd_en = (state_q == ST_READ);
  assign wr_en = (state_q == ST_WRITE);
  assign done  = (state_q == ST_DONE);

  // R10: the operand latch pulses only once per accepted start
  assert_single_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_op |=> !load_op);

  // R8: a read is always accepted before the matching write begins
  assert_read_before_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(load_rd, 2));

endmodule

// File: rtl/nibble_rot_unit.sv
module nibble_rot_unit
  import nrot_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [2*DATA_W-1:0] opcode_i,
  input  logic [ADDR_W-1:0]   ptr_i,
  input  logic [DATA_W-1:0]   acc_i,
  input  logic [FLAG_W-1:0]   flags_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                mem_rd_o,
  output logic                mem_wr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic                mem_ready_i,
  output logic [DATA_W-1:0]   acc_o,
  output logic [FLAG_W-1:0]   flags_o,
  output logic                done_o
);

  localparam int unsigned OPC_W = 2 * DATA_W;
  localparam int unsigned NIB_W = DATA_W / 2;

  logic              load_op, load_rd, load_res;
  logic              rd_en, wr_en, done;

  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] acc_q, mem_q, wdata_q, acc_res_q;
  logic [FLAG_W-1:0] flg_q, flg_res_q;

  logic [DATA_W-1:0] acc_new, mem_new;
  logic [FLAG_W-1:0] flg_new;

  nrot_ctrl #(.OPC_W(OPC_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .opcode_i    (opcode_i),
    .mem_ready_i (mem_ready_i),
    .load_op     (load_op),
    .load_rd     (load_rd),
    .load_res    (load_res),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .done        (done)
  );

  nrot_digit_alu #(.DATA_W(DATA_W)) u_alu (
    .acc_old (acc_q),
    .mem_old (mem_q),
    .flg_old (flg_q),
    .acc_new (acc_new),
    .mem_new (mem_new),
    .flg_new (flg_new)
  );

  // operand capture at accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      acc_q <= '0;
      flg_q <= '0;
    end else if (load_op) begin
      ptr_q <= ptr_i;
      acc_q <= acc_i;
      flg_q <= flags_i;
    end
  end

  // read data capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mem_q <= '0;
    else if (load_rd) mem_q <= mem_rdata_i;
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q   <= '0;
      acc_res_q <= '0;
      flg_res_q <= '0;
    end else if (load_res) begin
      wdata_q   <= mem_new;
      acc_res_q <= acc_new;
      flg_res_q <= flg_new;
    end
  end

  assign mem_addr_o  = ptr_q;
  assign mem_rd_o    = rd_en;
  assign mem_wr_o    = wr_en;
  assign mem_wdata_o = wdata_q;
  assign acc_o       = acc_res_q;
  assign flags_o     = flg_res_q;
  assign done_o      = done;

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !mem_ready_i) |=> (mem_rd_o && $stable(mem_addr_o)));

  assert_write_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && !mem_ready_i) |=> (mem_wr_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  assert_same_address_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_o) |-> ($stable(mem_addr_o) && $past(mem_rd_o, 2)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(mem_wr_o && mem_ready_i));

  assert_high_digit_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (acc_o[DATA_W-1:NIB_W] == acc_q[DATA_W-1:NIB_W]));

  assert_hn_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!flags_o[FLG_H] && !flags_o[FLG_N]));

  assert_carry_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flags_o[FLG_C] == flg_q[FLG_C]));

  assert_result_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_o && !done_o && !$past(done_o)) |-> ($stable(acc_o) && $stable(flags_o)));

endmodule

// File: tb/nibble_rot_unit_test.sv
module nibble_rot_unit_test;

  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [15:0] opcode_i;
  logic [15:0] ptr_i;
  logic [7:0]  acc_i;
  logic [7:0]  flags_i;
  logic [15:0] mem_addr_o;
  logic        mem_rd_o;
  logic        mem_wr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i;
  logic        mem_ready_i;
  logic [7:0]  acc_o;
  logic [7:0]  flags_o;
  logic        done_o;

  int total = 0;
  int bad   = 0;

  // memory model state
  logic [7:0]  mem_byte;
  int          lat;
  int          wait_cnt;
  int          rd_cnt, wr_cnt, done_cnt;
  logic [15:0] rd_addr, wr_addr;
  logic [7:0]  wr_data;

  nibble_rot_unit uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .opcode_i    (opcode_i),
    .ptr_i       (ptr_i),
    .acc_i       (acc_i),
    .flags_i     (flags_i),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ready_i (mem_ready_i),
    .acc_o       (acc_o),
    .flags_o     (flags_o),
    .done_o      (done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory responder: raises ready after lat wait cycles
  always @(negedge clk) begin
    if (mem_rd_o || mem_wr_o) begin
      if (wait_cnt >= lat) begin
        mem_ready_i = 1'b1;
        mem_rdata_i = mem_rd_o ? mem_byte : 8'hxx;
      end else begin
        mem_ready_i = 1'b0;
        wait_cnt    = wait_cnt + 1;
      end
    end else begin
      mem_ready_i = 1'b0;
      wait_cnt    = 0;
    end
  end

  // transaction observer
  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_rd_o && mem_ready_i) begin
        rd_cnt  <= rd_cnt + 1;
        rd_addr <= mem_addr_o;
      end
      if (mem_wr_o && mem_ready_i) begin
        wr_cnt  <= wr_cnt + 1;
        wr_addr <= mem_addr_o;
        wr_data <= mem_wdata_o;
      end
      if (done_o) done_cnt <= done_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_flags(input logic [7:0] a, input logic [7:0] f);
    logic [7:0] r;
    r    = f & 8'b0010_1001;
    r[7] = a[7];
    r[6] = (a == 8'h00);
    r[2] = ~(^a);
    return r;
  endfunction

  task automatic exec_op(input logic [7:0] a, input logic [7:0] m, input logic [7:0] f,
                         input logic [15:0] p, input int l, input bit poke);
    int n;
    int rd0, wr0, dn0;
    logic [7:0] ea, em;
    mem_byte = m;
    lat      = l;
    rd0 = rd_cnt; wr0 = wr_cnt; dn0 = done_cnt;
    @(negedge clk);
    start_i = 1'b1; opcode_i = 16'hED6F; acc_i = a; flags_i = f; ptr_i = p;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      // R10: start during busy period with different operands
      start_i = 1'b1; acc_i = ~a; flags_i = ~f; ptr_i = ~p;
      @(negedge clk);
      start_i = 1'b0;
    end
    n = 0;
    while (!done_o && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(done_o === 1'b1, "R9 done seen", done_o, 1);
    ea = {a[7:4], m[7:4]};
    em = {m[3:0], a[3:0]};
    check(acc_o === ea, "R4 acc result", acc_o, ea);
    check(flags_o === exp_flags(ea, f), "R5/R6/R7 flags", flags_o, exp_flags(ea, f));
    check(wr_data === em, "R3 write data", wr_data, em);
    check(rd_addr === p && wr_addr === p, "R2 addresses", {rd_addr, wr_addr}, {p, p});
    check(rd_cnt == rd0 + 1 && wr_cnt == wr0 + 1, poke ? "R10 access count" : "R8 access count",
          (rd_cnt - rd0) * 16 + (wr_cnt - wr0), 17);
    @(negedge clk);
    check(done_o === 1'b0 && done_cnt == dn0 + 1, "R9 single done pulse", done_cnt - dn0, 1);
    // R9 results held after completion
    check(acc_o === ea && flags_o === exp_flags(ea, f), "R9 results held", acc_o, ea);
  endtask

  task automatic try_bad_opcode(input logic [15:0] opc);
    int rd0, wr0, dn0;
    logic [7:0] a0, f0;
    rd0 = rd_cnt; wr0 = wr_cnt; dn0 = done_cnt; a0 = acc_o; f0 = flags_o;
    @(negedge clk);
    start_i = 1'b1; opcode_i = opc; acc_i = 8'h5A; flags_i = 8'hFF; ptr_i = 16'h1234;
    @(negedge clk);
    start_i = 1'b0;
    repeat (8) begin
      check(!mem_rd_o && !mem_wr_o, "R1 no strobe on bad opcode", {mem_rd_o, mem_wr_o}, 0);
      @(negedge clk);
    end
    check(rd_cnt == rd0 && wr_cnt == wr0 && done_cnt == dn0, "R1 no access on bad opcode",
          rd_cnt - rd0 + wr_cnt - wr0 + done_cnt - dn0, 0);
    check(acc_o === a0 && flags_o === f0, "R1 outputs unchanged", {acc_o, flags_o}, {a0, f0});
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; opcode_i = 16'h0000; ptr_i = 16'h0000;
    acc_i = 8'h00; flags_i = 8'h00; mem_rdata_i = 8'h00; mem_ready_i = 1'b0;
    mem_byte = 8'h00; lat = 0; wait_cnt = 0;
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
    rd_addr = 16'h0; wr_addr = 16'h0; wr_data = 8'h0;
    repeat (3) @(negedge clk);
    check(!mem_rd_o && !mem_wr_o && !done_o, "R11 strobes low in reset",
          {mem_rd_o, mem_wr_o, done_o}, 0);
    check(acc_o === 8'h00 && flags_o === 8'h00, "R11 outputs zero in reset",
          {acc_o, flags_o}, 0);
    // R1: a start during reset is not taken
    start_i = 1'b1; opcode_i = 16'hED6F;
    @(negedge clk);
    start_i = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rd_cnt == 0 && !mem_rd_o, "R11 idle after reset", rd_cnt, 0);

    // worked example
    exec_op(8'h7A, 8'h31, 8'h00, 16'h5000, 1, 1'b0);
    check(acc_o === 8'h73 && wr_data === 8'h1A, "R3 R4 worked example", {acc_o, wr_data}, 16'h731A);

    // R1: near-miss opcodes
    try_bad_opcode(16'hED6E);
    try_bad_opcode(16'hEC6F);
    try_bad_opcode(16'h6FED);
    try_bad_opcode(16'hED67);

    // zero result and sign result corners (R5)
    exec_op(8'h05, 8'h0C, 8'hFF, 16'hFFFF, 0, 1'b0);
    check(flags_o[6] === 1'b1, "R5 zero flag set", flags_o[6], 1);
    exec_op(8'h80, 8'h00, 8'h00, 16'h0000, 2, 1'b1);
    check(flags_o[7] === 1'b1 && flags_o[6] === 1'b0, "R5 sign flag set", flags_o[7:6], 2);

    // near-exhaustive sweep: every memory byte against every accumulator low digit
    for (int m = 0; m < 256; m++) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0]  a, f;
        logic [15:0] p;
        a = {4'((k * 5 + m) % 16), 4'(k)};
        f = 8'((m * 37 + k * 11) & 255);
        p = {8'(m), 8'(k * 13 + m)};
        exec_op(a, 8'(m), f, p, (m + k) % 3, ((m + k) % 17) == 0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule